// File: doc/BRIEF.md
# Audio Codec Mixer Register File

This block is the control register file of an audio codec. It holds 128 registers of 16 bits at even byte offsets in a 256-byte space. A host reaches them through a single-cycle read/write port. Each register comes out of reset with a fixed default value.

A few registers have special rules:
- The power status nibble at 0x26 cannot be written.
- The identification words at 0x28, 0x7C and 0x7E cannot be written.
- The three sample-rate registers accept writes only while their variable-rate enable in the extended control word at 0x2A is set.

Whenever a stored rate is rewritten, either by an accepted write or because it is forced back to 48 kHz, the block reports an event to the audio path. The event names the channel through a one-hot pulse and carries the new rate value.

Every access, valid or not, also produces a one-cycle pulse. The global block uses this pulse to clear its codec-access semaphore.

Top module: `codec_regfile`

## Requirements
- R1: A 16-bit access (`acc_size` = 1) at an even offset reads the stored register, and a write stores all 16 bits for registers without special rules. Read data is combinational in the same cycle.
- R2: Any read with `acc_size` other than 1 (0 = byte, 2 = 32-bit, 3 = reserved), or at an odd offset, returns 0xFFFF. Such writes change nothing.
- R3: After hardware reset, the registers hold these values:
  - 0x06 = 0x8000
  - 0x0C and 0x0E = 0x8008
  - 0x12 and 0x16 = 0x8808
  - 0x1E = 0x8000
  - 0x26 = 0x000F
  - 0x28 = 0x0809
  - 0x2A = 0x0009
  - 0x2C, 0x2E, 0x30, 0x32 and 0x34 = 0xBB80
  - all other offsets = 0

  After reset, `rate_pulse` and `sem_clr` are 0.
- R4: A valid 16-bit write of any value to offset 0x00 restores every register to its R3 default. In the next cycle it also raises all three `rate_pulse` bits with `rate_value` = 0xBB80.
- R5: Bits [3:0] of 0x26 are read-only. A write updates only bits [15:4].
- R6: Writes to 0x28, 0x7C and 0x7E are discarded.
- R7: A write to 0x2A stores the written value. If bit 0 of that value is clear, the write also forces 0x2C and 0x32 to 0xBB80, and in the next cycle `rate_pulse` bit 0 (record, 0x32) and bit 1 (playback, 0x2C) rise with `rate_value` = 0xBB80.
- R8: If bit 3 of a value written to 0x2A is clear, the write forces 0x34 to 0xBB80, and in the next cycle `rate_pulse` bit 2 (mic) rises with `rate_value` = 0xBB80.
- R9: Gating of the rate registers:
  - Writes to 0x2C and 0x32 are accepted only while bit 0 of 0x2A is set.
  - Writes to 0x34 are accepted only while bit 3 of 0x2A is set.
  - An accepted write raises the matching single `rate_pulse` bit for one cycle in the next cycle, with `rate_value` equal to the written data.
  - A dropped write changes nothing and raises no pulse.
- R10: `sem_clr` is high for exactly the cycle after each cycle in which `acc_valid` is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | Access width: 0 byte, 1 half-word, 2 word, 3 reserved |
| acc_addr | input | 8 | Byte offset |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data (combinational) |
| sem_clr | output | 1 | Pulse one cycle after any access |
| rate_pulse | output | 3 | One-hot rate event: bit 0 record, bit 1 playback, bit 2 mic |
| rate_value | output | 16 | Rate carried by the current event |

## Verification
The assertions assume two things about the inputs:
- The control inputs hold defined values at every clock edge after reset.
- `acc_valid` is low while reset is held, so no property looks back at an access made during reset.

The bench follows both rules. It drives each access for exactly one cycle, changing inputs only on the falling edge, and it keeps `acc_valid` low during and just after reset. Its random traffic mixes every access width with odd offsets, and it steers offsets toward the rate, control and locked registers. As a result, toggling the rate enables and the gated or dropped rate writes happen many times within the legal input space.

// File: rtl/codec_regfile.sv
module codec_regfile #(
  parameter logic [15:0] VEND_W0 = 16'h0000,
  parameter logic [15:0] VEND_W1 = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [1:0]  acc_size,
  input  logic [7:0]  acc_addr,
  input  logic [15:0] acc_wdata,
  output logic [15:0] acc_rdata,
  output logic        sem_clr,
  output logic [2:0]  rate_pulse,
  output logic [15:0] rate_value
);
  localparam int NREG = 128;
  localparam logic [15:0] R48K = 16'hBB80;
  localparam logic [6:0] I_PWR  = 7'h13;
  localparam logic [6:0] I_XCTL = 7'h15;
  localparam logic [6:0] I_PLAY = 7'h16;
  localparam logic [6:0] I_REC  = 7'h19;
  localparam logic [6:0] I_MIC  = 7'h1A;

  function automatic logic [15:0] dflt(input logic [7:0] off);
    case (off)
      8'h06, 8'h1E:                      dflt = 16'h8000;
      8'h0C, 8'h0E:                      dflt = 16'h8008;
      8'h12, 8'h16:                      dflt = 16'h8808;
      8'h26:                             dflt = 16'h000F;
      8'h28:                             dflt = 16'h0809;
      8'h2A:                             dflt = 16'h0009;
      8'h2C, 8'h2E, 8'h30, 8'h32, 8'h34: dflt = R48K;
      8'h7C:                             dflt = VEND_W0;
      8'h7E:                             dflt = VEND_W1;
      default:                           dflt = 16'h0000;
    endcase
  endfunction

  logic [15:0] regs [NREG];
  logic        ok_half;
  logic        wr_ok;
  logic [6:0]  idx;

  assign idx       = acc_addr[7:1];
  assign ok_half   = (acc_size == 2'd1) && !acc_addr[0];
  assign wr_ok     = acc_valid && acc_write && ok_half;
  assign acc_rdata = ok_half ? regs[idx] : 16'hFFFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= dflt(8'(2 * i));
      sem_clr    <= 1'b0;
      rate_pulse <= 3'b000;
      rate_value <= 16'h0000;
    end else begin
      sem_clr    <= acc_valid;
      rate_pulse <= 3'b000;
      if (wr_ok) begin
        case (acc_addr)
          8'h00: begin
            for (int i = 0; i < NREG; i++) regs[i] <= dflt(8'(2 * i));
            rate_pulse <= 3'b111;
            rate_value <= R48K;
          end
          8'h26: regs[I_PWR] <= {acc_wdata[15:4], regs[I_PWR][3:0]};
          8'h28, 8'h7C, 8'h7E: ;
          8'h2A: begin
            regs[I_XCTL] <= acc_wdata;
            if (!acc_wdata[0]) begin
              regs[I_PLAY]    <= R48K;
              regs[I_REC]     <= R48K;
              rate_pulse[1:0] <= 2'b11;
              rate_value      <= R48K;
            end
            if (!acc_wdata[3]) begin
              regs[I_MIC]   <= R48K;
              rate_pulse[2] <= 1'b1;
              rate_value    <= R48K;
            end
          end
          8'h2C: if (regs[I_XCTL][0]) begin
            regs[I_PLAY] <= acc_wdata;
            rate_pulse   <= 3'b010;
            rate_value   <= acc_wdata;
          end
          8'h32: if (regs[I_XCTL][0]) begin
            regs[I_REC] <= acc_wdata;
            rate_pulse  <= 3'b001;
            rate_value  <= acc_wdata;
          end
          8'h34: if (regs[I_XCTL][3]) begin
            regs[I_MIC] <= acc_wdata;
            rate_pulse  <= 3'b100;
            rate_value  <= acc_wdata;
          end
          default: regs[idx] <= acc_wdata;
        endcase
      end
    end
  end
endmodule

// File: rtl/codec_regfile_chk.sv
module codec_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [1:0]  acc_size,
  input logic [7:0]  acc_addr,
  input logic [15:0] acc_rdata,
  input logic        sem_clr,
  input logic [2:0]  rate_pulse,
  input logic [15:0] rate_value
);
  logic hw;
  assign hw = acc_valid && acc_write && (acc_size == 2'd1);

  p_sem_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> sem_clr);
  p_sem_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !sem_clr);
  p_bad_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && (acc_size != 2'd1 || acc_addr[0])) |-> acc_rdata == 16'hFFFF);
  p_ro_nibble_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_size == 2'd1 && acc_addr == 8'h26) |-> acc_rdata[3:0] == 4'hF);
  p_id_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_size == 2'd1 && acc_addr == 8'h28) |-> acc_rdata == 16'h0809);
  p_soft_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hw && acc_addr == 8'h00) |=> (rate_pulse == 3'b111 && rate_value == 16'hBB80));
  p_rec_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rate_pulse[0] |-> $past(hw && (acc_addr == 8'h32 || acc_addr == 8'h2A || acc_addr == 8'h00)));
  p_play_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rate_pulse[1] |-> $past(hw && (acc_addr == 8'h2C || acc_addr == 8'h2A || acc_addr == 8'h00)));
  p_mic_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rate_pulse[2] |-> $past(hw && (acc_addr == 8'h34 || acc_addr == 8'h2A || acc_addr == 8'h00)));
  p_forced_rate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_pulse[0] && rate_pulse[1]) |-> rate_value == 16'hBB80);
endmodule

bind codec_regfile codec_regfile_chk u_chk (.*);

// File: tb/tb_codec_regfile.sv
module tb_codec_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [1:0]  acc_size = 2'd0;
  logic [7:0]  acc_addr = 8'h00;
  logic [15:0] acc_wdata = 16'h0000;
  logic [15:0] acc_rdata;
  logic        sem_clr;
  logic [2:0]  rate_pulse;
  logic [15:0] rate_value;

  int total = 0;
  int fails = 0;
  logic [15:0] m [128];

  always #2 clk = ~clk;

  codec_regfile dut (.*);

  function automatic logic [15:0] spec_dflt(input int off);
    case (off)
      'h06, 'h1E:                   return 16'h8000;
      'h0C, 'h0E:                   return 16'h8008;
      'h12, 'h16:                   return 16'h8808;
      'h26:                         return 16'h000F;
      'h28:                         return 16'h0809;
      'h2A:                         return 16'h0009;
      'h2C, 'h2E, 'h30, 'h32, 'h34: return 16'hBB80;
      default:                      return 16'h0000;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 128; i++) m[i] = spec_dflt(2 * i);
  endtask

  task automatic check(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sz, input logic [7:0] a, input logic [15:0] d);
    logic [2:0] ep = 3'b000;
    logic [15:0] ev = 16'h0000;
    string tag = "R9";
    if (sz != 2'd1 || a[0]) tag = "R2";
    else begin
      case (a)
        8'h00: begin model_reset(); ep = 3'b111; ev = 16'hBB80; tag = "R4"; end
        8'h26: begin m[8'h13] = {d[15:4], m[8'h13][3:0]}; tag = "R5"; end
        8'h28, 8'h7C, 8'h7E: tag = "R6";
        8'h2A: begin
          m[8'h15] = d; tag = "R7";
          if (!d[0]) begin m[8'h16] = 16'hBB80; m[8'h19] = 16'hBB80; ep[1:0] = 2'b11; ev = 16'hBB80; end
          if (!d[3]) begin m[8'h1A] = 16'hBB80; ep[2] = 1'b1; ev = 16'hBB80; if (d[0]) tag = "R8"; end
        end
        8'h2C: if (m[8'h15][0]) begin m[8'h16] = d; ep = 3'b010; ev = d; end
        8'h32: if (m[8'h15][0]) begin m[8'h19] = d; ep = 3'b001; ev = d; end
        8'h34: if (m[8'h15][3]) begin m[8'h1A] = d; ep = 3'b100; ev = d; end
        default: begin m[a[7:1]] = d; tag = "R1"; end
      endcase
    end
    acc_valid = 1'b1; acc_write = 1'b1; acc_size = sz; acc_addr = a; acc_wdata = d;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    check(sem_clr == 1'b1, "R10", {15'd0, sem_clr}, 16'd1);
    check(rate_pulse == ep, tag, {13'd0, rate_pulse}, {13'd0, ep});
    if (ep != 3'b000) check(rate_value == ev, tag, rate_value, ev);
  endtask

  task automatic rd(input logic [1:0] sz, input logic [7:0] a, input string req);
    logic [15:0] exp = (sz == 2'd1 && !a[0]) ? m[a[7:1]] : 16'hFFFF;
    acc_valid = 1'b1; acc_write = 1'b0; acc_size = sz; acc_addr = a;
    #1;
    check(acc_rdata == exp, req, acc_rdata, exp);
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sem_clr == 1'b0, "R3", {15'd0, sem_clr}, 16'd0);
    check(rate_pulse == 3'b000, "R3", {13'd0, rate_pulse}, 16'd0);
    for (int i = 0; i < 128; i++) rd(2'd1, 8'(2 * i), "R3");
    @(negedge clk);
    check(sem_clr == 1'b0, "R10", {15'd0, sem_clr}, 16'd0);

    wr(2'd1, 8'h18, 16'h1234); rd(2'd1, 8'h18, "R1");
    rd(2'd0, 8'h06, "R2"); rd(2'd2, 8'h06, "R2"); rd(2'd1, 8'h07, "R2");
    wr(2'd0, 8'h18, 16'hAAAA); wr(2'd2, 8'h18, 16'h5555); wr(2'd1, 8'h19, 16'h0F0F);
    rd(2'd1, 8'h18, "R2");
    wr(2'd1, 8'h26, 16'hFFF0); rd(2'd1, 8'h26, "R5");
    wr(2'd1, 8'h26, 16'h0000); rd(2'd1, 8'h26, "R5");
    wr(2'd1, 8'h7C, 16'h1111); rd(2'd1, 8'h7C, "R6");
    wr(2'd1, 8'h28, 16'h2222); rd(2'd1, 8'h28, "R6");
    wr(2'd1, 8'h2C, 16'h5622); rd(2'd1, 8'h2C, "R9");
    wr(2'd1, 8'h34, 16'hAC44); rd(2'd1, 8'h34, "R9");
    wr(2'd1, 8'h2A, 16'h0008); rd(2'd1, 8'h2C, "R7"); rd(2'd1, 8'h32, "R7");
    wr(2'd1, 8'h2C, 16'h1F40); rd(2'd1, 8'h2C, "R9");
    wr(2'd1, 8'h34, 16'h3E80); rd(2'd1, 8'h34, "R9");
    wr(2'd1, 8'h2A, 16'h0001); rd(2'd1, 8'h34, "R8");
    wr(2'd1, 8'h34, 16'h1234); rd(2'd1, 8'h34, "R9");
    wr(2'd1, 8'h00, 16'hDEAD);
    for (int i = 0; i < 128; i++) rd(2'd1, 8'(2 * i), "R4");

    for (int n = 0; n < 600; n++) begin
      logic [1:0] sz;
      logic [7:0] a;
      logic [15:0] d;
      int pick;
      sz = ($urandom % 10 < 7) ? 2'd1 : 2'($urandom % 4);
      pick = $urandom % 8;
      case (pick)
        0: a = 8'h2A;
        1: a = 8'h2C;
        2: a = 8'h32;
        3: a = 8'h34;
        4: a = 8'h26;
        default: a = 8'($urandom % 256);
      endcase
      if (a == 8'h00 && ($urandom % 4 != 0)) a = 8'h02;
      d = 16'($urandom);
      if ($urandom % 2 == 0) wr(sz, a, d);
      else rd(sz, a, (sz == 2'd1 && !a[0]) ? "R1" : "R2");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule